// File: doc/BRIEF.md
# Strap-Configured Downstream Port Power Controller

This block sits beside a hub's port logic and owns the pins that switch power to the downstream ports. The same pads do two jobs. While the global reset is held, they are read as configuration straps. Once reset is released, they become power-enable or upstream-link status outputs. The values read at release set the active level of the power enables, ganged or per-port switching, whether power switching and over-current sensing exist at all, per-port battery-charging support, the serial bus mode and its target address bits, and automatic charge mode.

After capture, the block follows the hub logic's per-port power requests. It drives the power-enable pads at the captured active level. It filters the four active-low over-current inputs. A confirmed fault cuts power until the hub logic withdraws its request and then issues it again. Four status-capable pads can carry upstream link state: SuperSpeed suspended, SuperSpeed connected, high-speed connected and high-speed suspended. Each of them drives only when its enable bit is set. During reset, and for one cycle after it, no pad is driven, so the external straps are never overdriven.

Top module: `port_pwr_strap_ctl`

## Requirements
- R1: While `rst_n` is low, every pad output enable is 0, every decoded configuration output is 0 and every pad output value is 0.
- R2: In the first cycle after `rst_n` rises, all output enables stay 0. From the second rising clock edge on, `pwr_pad_oe` is all ones when power switching is enabled, and `sts_pad_oe[k]` equals `sts_en[k]`.
- R3: Straps are sampled only at the first rising clock edge after reset release. Later changes on any pad input leave every decoded configuration output unchanged.
- R4: A 1 on `pol_pad_in` makes a powered port drive 1 on its `pwr_pad_out` bit, and an unpowered port drive 0. A 0 on `pol_pad_in` inverts both levels. `cfg_pol_hi` reports the captured level.
- R5: In individual mode, port i is powered exactly when `pwr_req[i]` is 1, with one clock of latency.
- R6: In ganged mode (`sts_pad_in[2]` is 1 at capture and power switching is enabled), all ports are powered when any bit of `pwr_req` is 1, and `cfg_gang` reads 1.
- R7: If `sts_pad_in[1]` is 1 at capture, power switching is disabled. Then `cfg_pm_en` reads 0, `pwr_pad_oe` stays 0, `cfg_gang` reads 0 and the over-current inputs are ignored (`ovc_flag` stays 0).
- R8: `cfg_bc_en[i]` is the power-pad value of port i captured at reset. It reads 1 only when power switching is enabled and individual mode is selected. A 0 on `sts_pad_in[3]` at capture sets `cfg_auto_chg`. `cfg_cdp_ok` equals `cfg_bc_en`, except that bit 0 is forced to 0 when `cfg_auto_chg` is 1.
- R9: A 1 on `sts_pad_in[0]` at capture selects I2C (`cfg_i2c_mode`=1, `cfg_smb_addr`=0). A 0 selects SMBus, and `cfg_smb_addr` = {captured `sts_pad_in[2]`, captured `sts_pad_in[1]`} (address bits 2 and 1).
- R10: An `ovc_n` low level lasting 3 clock cycles causes no action. A low level of 4 or more cycles sets `ovc_flag` for that port while the input stays low, and removes power from the port.
- R11: A tripped port stays unpowered after the fault clears, until its request drops to 0 and rises again. In ganged mode a fault on any port removes power from all ports.
- R12: Status pad order is 0 SuperSpeed suspended, 1 SuperSpeed connected, 2 high-speed connected, 3 high-speed suspended. After enabling, `sts_pad_out[k]` = `sts_en[k]` AND `link_sts[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low global reset |
| pwr_pad_in | input | NUM_PORTS | Power pad inputs, read as charging straps |
| pwr_pad_out | output | NUM_PORTS | Power-enable pad values |
| pwr_pad_oe | output | NUM_PORTS | Power pad output enables |
| sts_pad_in | input | 4 | Status-capable pad inputs: bus mode, power-management disable, gang, auto-charge disable |
| sts_pad_out | output | 4 | Link status pad values |
| sts_pad_oe | output | 4 | Status pad output enables |
| pol_pad_in | input | 1 | Power-enable polarity strap |
| pwr_req | input | NUM_PORTS | Per-port power request from hub logic |
| ovc_n | input | NUM_PORTS | Active-low over-current inputs |
| link_sts | input | 4 | Upstream link conditions, same order as status pads |
| sts_en | input | 4 | Per-pad status drive enables |
| cfg_bc_en | output | NUM_PORTS | Effective battery-charging support |
| cfg_cdp_ok | output | NUM_PORTS | Charging-downstream-port mode allowed |
| cfg_pm_en | output | 1 | Power switching and over-current sensing enabled |
| cfg_gang | output | 1 | Ganged switching in effect |
| cfg_pol_hi | output | 1 | Power enables are active high |
| cfg_i2c_mode | output | 1 | Serial bus in I2C mode |
| cfg_smb_addr | output | 2 | SMBus target address bits 2:1 |
| cfg_auto_chg | output | 1 | Automatic charge mode enabled |
| ovc_flag | output | NUM_PORTS | Filtered over-current condition |

## Verification
The bench aims at the release edge. A design that opens its output enables in the capture cycle would fight the straps, and one that keeps sampling would let later pad traffic rewrite the configuration. The bench drives the filter boundary with a 3-cycle pulse, which must be ignored, and a 4-cycle pulse, which must trip the port. An off-by-one counter either trips on noise or misses real faults. The bench also checks the trip latch across the fault's removal and the request cycle. It checks ganged fault spreading with active-low polarity. Last, it checks the interaction masks: charging is reported as off under ganged or unswitched configurations, port 0 loses the charging-downstream-port mode in automatic mode, and a design that mixes these up would report charging support on a port that cannot switch.

// File: rtl/pps_pkg.sv
package pps_pkg;
   localparam int NUM_STS = 4;
   // status pad roles after reset; strap roles before it
   localparam int ST_SS_SUSP = 0;   // strap: bus mode (1 = I2C)
   localparam int ST_SS_CONN = 1;   // strap: power-management disable
   localparam int ST_HS_CONN = 2;   // strap: gang select
   localparam int ST_HS_SUSP = 3;   // strap: auto-charge disable

   typedef struct packed {
      logic i2c;
      logic pm_dis;
      logic gang;
      logic auto_dis;
      logic pol_hi;
   } strap_cfg_t;

   function automatic logic drive_level(input logic on, input logic pol_hi);
      return pol_hi ? on : ~on;
   endfunction
endpackage

// File: rtl/pps_strap_cap.sv
module pps_strap_cap
   import pps_pkg::*;
#(
   parameter int NUM_PORTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] pwr_pad_in,
   input  logic [NUM_STS-1:0]   sts_pad_in,
   input  logic                 pol_pad_in,
   output logic [NUM_PORTS-1:0] bc_strap,
   output strap_cfg_t           cfg,
   output logic                 cap_done,
   output logic                 oe_on
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bc_strap <= '0;
         cfg      <= '0;
         cap_done <= 1'b0;
         oe_on    <= 1'b0;
      end else begin
         if (!cap_done) begin
            bc_strap     <= pwr_pad_in;
            cfg.i2c      <= sts_pad_in[ST_SS_SUSP];
            cfg.pm_dis   <= sts_pad_in[ST_SS_CONN];
            cfg.gang     <= sts_pad_in[ST_HS_CONN];
            cfg.auto_dis <= sts_pad_in[ST_HS_SUSP];
            cfg.pol_hi   <= pol_pad_in;
         end
         cap_done <= 1'b1;
         oe_on    <= cap_done;
      end
   end
endmodule

// File: rtl/pps_ovc_filt.sv
module pps_ovc_filt #(
   parameter int SYNC_STAGES = 2,
   parameter int DEGLITCH    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ovc_n_in,
   output logic evt
);
   localparam int CW = (DEGLITCH > 2) ? $clog2(DEGLITCH) : 1;
   localparam logic [CW-1:0] LAST = CW'(DEGLITCH - 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DEGLITCH < 2) begin : g_bad_dg
         $error("DEGLITCH must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sq;
   logic [CW-1:0]          cnt;
   logic                   low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq <= '1;
      else        sq <= {sq[SYNC_STAGES-2:0], ovc_n_in};
   end

   assign low = ~sq[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         evt <= 1'b0;
      end else if (!low) begin
         cnt <= '0;
         evt <= 1'b0;
      end else if (cnt == LAST) begin
         evt <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pps_port_pwr.sv
module pps_port_pwr #(
   parameter int NUM_PORTS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 gang,
   input  logic [NUM_PORTS-1:0] req,
   input  logic [NUM_PORTS-1:0] evt,
   output logic [NUM_PORTS-1:0] pwr_on
);
   logic [NUM_PORTS-1:0] trip_q, trip_d, req_eff, evt_eff;
   logic                 any_req, any_evt;

   assign any_req = |req;
   assign any_evt = |evt;

   generate
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
         assign req_eff[i] = gang ? any_req : req[i];
         assign evt_eff[i] = gang ? any_evt : evt[i];
         assign trip_d[i]  = run & ((trip_q[i] & req_eff[i]) | evt_eff[i]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trip_q <= '0;
         pwr_on <= '0;
      end else begin
         trip_q <= trip_d;
         pwr_on <= {NUM_PORTS{run}} & req_eff & ~trip_d;
      end
   end
endmodule

// File: rtl/port_pwr_strap_ctl.sv
module port_pwr_strap_ctl
   import pps_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DEGLITCH    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] pwr_pad_in,
   output logic [NUM_PORTS-1:0] pwr_pad_out,
   output logic [NUM_PORTS-1:0] pwr_pad_oe,
   input  logic [3:0]           sts_pad_in,
   output logic [3:0]           sts_pad_out,
   output logic [3:0]           sts_pad_oe,
   input  logic                 pol_pad_in,
   input  logic [NUM_PORTS-1:0] pwr_req,
   input  logic [NUM_PORTS-1:0] ovc_n,
   input  logic [3:0]           link_sts,
   input  logic [3:0]           sts_en,
   output logic [NUM_PORTS-1:0] cfg_bc_en,
   output logic [NUM_PORTS-1:0] cfg_cdp_ok,
   output logic                 cfg_pm_en,
   output logic                 cfg_gang,
   output logic                 cfg_pol_hi,
   output logic                 cfg_i2c_mode,
   output logic [1:0]           cfg_smb_addr,
   output logic                 cfg_auto_chg,
   output logic [NUM_PORTS-1:0] ovc_flag
);
   generate
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("NUM_PORTS must be at least 1");
      end
   endgenerate

   strap_cfg_t           cfg;
   logic [NUM_PORTS-1:0] bc_strap, evt, pwr_on;
   logic                 cap_done, oe_on, run;

   pps_strap_cap #(.NUM_PORTS(NUM_PORTS)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_pad_in (pwr_pad_in),
      .sts_pad_in (sts_pad_in),
      .pol_pad_in (pol_pad_in),
      .bc_strap   (bc_strap),
      .cfg        (cfg),
      .cap_done   (cap_done),
      .oe_on      (oe_on)
   );

   generate
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_filt
         pps_ovc_filt #(.SYNC_STAGES(SYNC_STAGES), .DEGLITCH(DEGLITCH)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .ovc_n_in (ovc_n[i]),
            .evt      (evt[i])
         );
      end
   endgenerate

   assign cfg_pm_en    = cap_done & ~cfg.pm_dis;
   assign cfg_gang     = cfg_pm_en & cfg.gang;
   assign cfg_pol_hi   = cap_done & cfg.pol_hi;
   assign cfg_i2c_mode = cap_done & cfg.i2c;
   assign cfg_smb_addr = (cap_done & ~cfg.i2c) ? {cfg.gang, cfg.pm_dis} : 2'b00;
   assign cfg_auto_chg = cap_done & ~cfg.auto_dis;
   assign run          = oe_on & cfg_pm_en;

   pps_port_pwr #(.NUM_PORTS(NUM_PORTS)) u_pwr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .gang   (cfg_gang),
      .req    (pwr_req),
      .evt    (evt),
      .pwr_on (pwr_on)
   );

   generate
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_out
         assign cfg_bc_en[i]   = bc_strap[i] & cfg_pm_en & ~cfg.gang;
         if (i == 0) begin : g_p0
            assign cfg_cdp_ok[i] = cfg_bc_en[i] & ~cfg_auto_chg;
         end else begin : g_pn
            assign cfg_cdp_ok[i] = cfg_bc_en[i];
         end
         assign pwr_pad_oe[i]  = run;
         assign pwr_pad_out[i] = run & drive_level(pwr_on[i], cfg.pol_hi);
         assign ovc_flag[i]    = cfg_pm_en & evt[i];
      end
   endgenerate

   assign sts_pad_oe  = {4{oe_on}} & sts_en;
   assign sts_pad_out = {4{oe_on}} & sts_en & link_sts;
endmodule

// File: rtl/port_pwr_strap_ctl_chk.sv
module port_pwr_strap_ctl_chk #(
   parameter int NUM_PORTS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_PORTS-1:0] pwr_pad_out,
   input logic [NUM_PORTS-1:0] pwr_pad_oe,
   input logic [3:0]           sts_pad_out,
   input logic [3:0]           sts_pad_oe,
   input logic [NUM_PORTS-1:0] cfg_bc_en,
   input logic [NUM_PORTS-1:0] cfg_cdp_ok,
   input logic                 cfg_pm_en,
   input logic                 cfg_gang,
   input logic                 cfg_i2c_mode,
   input logic [1:0]           cfg_smb_addr,
   input logic                 cfg_auto_chg,
   input logic [NUM_PORTS-1:0] ovc_flag
);
   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   // R2
   oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc < 2'd2) |-> (pwr_pad_oe == '0 && sts_pad_oe == '0));

   // R3
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2) |-> ($stable(cfg_bc_en) && $stable(cfg_pm_en) && $stable(cfg_i2c_mode)
                         && $stable(cfg_smb_addr) && $stable(cfg_auto_chg)));

   // R6
   gang_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_gang |-> (pwr_pad_out == '0 || pwr_pad_out == '1));

   // R7
   pm_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_pm_en |-> (pwr_pad_oe == '0 && ovc_flag == '0 && !cfg_gang));

   // R8
   bc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pm_en || cfg_gang) |-> (cfg_bc_en == '0));

   // R8
   cdp_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_auto_chg |-> !cfg_cdp_ok[0]);

   // R9
   i2c_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_i2c_mode |-> (cfg_smb_addr == 2'b00));

   // R12
   sts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_pad_out & ~sts_pad_oe) == 4'b0000);
endmodule

bind port_pwr_strap_ctl port_pwr_strap_ctl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pwr_pad_out  (pwr_pad_out),
   .pwr_pad_oe   (pwr_pad_oe),
   .sts_pad_out  (sts_pad_out),
   .sts_pad_oe   (sts_pad_oe),
   .cfg_bc_en    (cfg_bc_en),
   .cfg_cdp_ok   (cfg_cdp_ok),
   .cfg_pm_en    (cfg_pm_en),
   .cfg_gang     (cfg_gang),
   .cfg_i2c_mode (cfg_i2c_mode),
   .cfg_smb_addr (cfg_smb_addr),
   .cfg_auto_chg (cfg_auto_chg),
   .ovc_flag     (ovc_flag)
);

// File: tb/port_pwr_strap_ctl_tb_top.sv
module port_pwr_strap_ctl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pwr_pad_in = '0, sts_pad_in = '0, pwr_req = '0, ovc_n = '1;
   logic [3:0] link_sts = '0, sts_en = '0;
   logic       pol_pad_in = 1'b0;
   logic [3:0] pwr_pad_out, pwr_pad_oe, sts_pad_out, sts_pad_oe;
   logic [3:0] cfg_bc_en, cfg_cdp_ok, ovc_flag;
   logic       cfg_pm_en, cfg_gang, cfg_pol_hi, cfg_i2c_mode, cfg_auto_chg;
   logic [1:0] cfg_smb_addr;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   port_pwr_strap_ctl dut_i (
      .clk(clk), .rst_n(rst_n),
      .pwr_pad_in(pwr_pad_in), .pwr_pad_out(pwr_pad_out), .pwr_pad_oe(pwr_pad_oe),
      .sts_pad_in(sts_pad_in), .sts_pad_out(sts_pad_out), .sts_pad_oe(sts_pad_oe),
      .pol_pad_in(pol_pad_in), .pwr_req(pwr_req), .ovc_n(ovc_n),
      .link_sts(link_sts), .sts_en(sts_en),
      .cfg_bc_en(cfg_bc_en), .cfg_cdp_ok(cfg_cdp_ok), .cfg_pm_en(cfg_pm_en),
      .cfg_gang(cfg_gang), .cfg_pol_hi(cfg_pol_hi), .cfg_i2c_mode(cfg_i2c_mode),
      .cfg_smb_addr(cfg_smb_addr), .cfg_auto_chg(cfg_auto_chg), .ovc_flag(ovc_flag)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, req, act, exp);
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // sts bits: 0 bus mode, 1 pm disable, 2 gang, 3 auto disable
   task automatic start(input logic [3:0] bc, input logic [3:0] sts, input logic pol);
      @(negedge clk);
      rst_n = 1'b0; pwr_req = '0; ovc_n = '1;
      pwr_pad_in = bc; sts_pad_in = sts; pol_pad_in = pol;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; sts_en = '1; pwr_pad_in = '1; sts_pad_in = 4'b0001; pol_pad_in = 1'b1;
      cyc(3);
      eq("R1 oe", {pwr_pad_oe, sts_pad_oe}, 8'h00);
      eq("R1 pad out", {pwr_pad_out, sts_pad_out}, 8'h00);
      eq("R1 cfg", {cfg_bc_en, cfg_cdp_ok, cfg_pm_en, cfg_gang, cfg_pol_hi,
                    cfg_i2c_mode, cfg_smb_addr, cfg_auto_chg}, 15'h0);
   endtask

   task automatic t_capture_i2c;
      sts_en = 4'b0000;
      pwr_pad_in = 4'b1010; sts_pad_in = 4'b1001; pol_pad_in = 1'b1;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      eq("R2 oe low first cycle", {pwr_pad_oe, sts_pad_oe}, 8'h00);
      eq("R8 bc", cfg_bc_en, 4'b1010);
      eq("R8 cdp no auto", cfg_cdp_ok, 4'b1010);
      eq("R9 i2c", {cfg_i2c_mode, cfg_smb_addr}, 3'b100);
      eq("R4 pol", cfg_pol_hi, 1'b1);
      @(negedge clk);
      eq("R2 pwr oe on", pwr_pad_oe, 4'b1111);
      eq("R2 sts oe gated", sts_pad_oe, 4'b0000);
   endtask

   task automatic t_frozen;
      pwr_pad_in = 4'b0101; sts_pad_in = 4'b0110; pol_pad_in = 1'b0;
      cyc(3);
      eq("R3 cfg frozen", {cfg_bc_en, cfg_pm_en, cfg_gang, cfg_pol_hi, cfg_i2c_mode,
                           cfg_smb_addr, cfg_auto_chg}, {4'b1010, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0});
   endtask

   task automatic t_individual;
      pwr_req = 4'b0101;
      @(negedge clk);
      eq("R5 R4 indiv hi", pwr_pad_out, 4'b0101);
      pwr_req = 4'b1100;
      @(negedge clk);
      eq("R5 indiv change", pwr_pad_out, 4'b1100);
   endtask

   task automatic t_status;
      sts_en = 4'b0101; link_sts = 4'b1111;
      #1;
      eq("R12 sts oe", sts_pad_oe, 4'b0101);
      eq("R12 sts out", sts_pad_out, 4'b0101);
      link_sts = 4'b0110;
      #1;
      eq("R12 sts follow", sts_pad_out, 4'b0100);
      sts_en = 4'b0000;
   endtask

   task automatic t_ovc_filter;
      pwr_req = 4'b1111;
      cyc(2);
      ovc_n[1] = 1'b0; cyc(3); ovc_n[1] = 1'b1;
      cyc(8);
      eq("R10 3-cycle glitch ignored", {pwr_pad_out, ovc_flag}, 8'hF0);
      ovc_n[2] = 1'b0; cyc(8);
      eq("R10 flag", ovc_flag, 4'b0100);
      eq("R10 trip", pwr_pad_out, 4'b1011);
      ovc_n[2] = 1'b1; cyc(6);
      eq("R11 held after clear", pwr_pad_out, 4'b1011);
      pwr_req[2] = 1'b0; @(negedge clk);
      pwr_req[2] = 1'b1; @(negedge clk);
      eq("R11 reissue", pwr_pad_out, 4'b1111);
      ovc_n[0] = 1'b0; cyc(4); ovc_n[0] = 1'b1;
      cyc(8);
      eq("R10 4-cycle trips", pwr_pad_out, 4'b1110);
   endtask

   task automatic t_gang_low;
      // SMBus, pm enabled, gang, auto on, active low
      start(4'b1111, 4'b0100, 1'b0);
      eq("R6 gang flag", cfg_gang, 1'b1);
      eq("R8 bc masked gang", {cfg_bc_en, cfg_cdp_ok}, 8'h00);
      eq("R9 smb addr", {cfg_i2c_mode, cfg_smb_addr}, 3'b010);
      eq("R8 auto", cfg_auto_chg, 1'b1);
      eq("R4 idle active low", pwr_pad_out, 4'b1111);
      pwr_req = 4'b0100; @(negedge clk);
      eq("R6 R4 gang on low", pwr_pad_out, 4'b0000);
      ovc_n[3] = 1'b0; cyc(8); ovc_n[3] = 1'b1; cyc(6);
      eq("R11 gang trip all", pwr_pad_out, 4'b1111);
      pwr_req = 4'b0000; @(negedge clk);
      pwr_req = 4'b0010; @(negedge clk);
      eq("R11 gang reissue", pwr_pad_out, 4'b0000);
   endtask

   task automatic t_pm_off;
      start(4'b1111, 4'b0010, 1'b1);
      eq("R7 pm off", {cfg_pm_en, cfg_gang, pwr_pad_oe}, 6'h00);
      eq("R8 bc masked pm", cfg_bc_en, 4'b0000);
      eq("R9 smb addr pm", cfg_smb_addr, 2'b01);
      pwr_req = 4'b1111; ovc_n = 4'b0000; cyc(10);
      eq("R7 ovc ignored", {ovc_flag, pwr_pad_out}, 8'h00);
      ovc_n = '1;
   endtask

   task automatic t_cdp_mask;
      start(4'b1111, 4'b0001, 1'b1);
      eq("R8 bc indiv", cfg_bc_en, 4'b1111);
      eq("R8 cdp port0 masked", cfg_cdp_ok, 4'b1110);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_capture_i2c();
      t_frozen();
      t_individual();
      t_status();
      t_ovc_filter();
      t_gang_low();
      t_pm_off();
      t_cdp_mask();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule